// File: doc/BRIEF.md
# Raster Line Event Interrupt Unit

This unit watches the vertical position reported by a display timing generator and raises events when the scan reaches lines that software has chosen. Four event sources each compare against their own target line. When a source's line begins, its bit in a sticky status word is set and stays set until software writes a one to that bit through a clear register. A mask register selects which sources may drive the single level-sensitive interrupt request.

The unit also holds a trigger register with two further target lines. When either line begins, a one-cycle strobe is sent to a context loader. One strobe is for a single-buffered register load and the other is for a double-buffered load. The timing generator supplies the current line number and a strobe that marks the first pixel of each line. Software reaches the registers through a simple word-addressed write port and a combinational read port.

Top module: `line_irq_unit`

## Requirements
- R1: After a synchronous reset, the status, mask, trigger and line target registers are all zero, and irq, sb_load and db_load are low.
- R2: Source n has a target line register at word address 4+n. The target line occupies bits 28:16. Reading the register back returns only those bits, and all other bits read as zero.
- R3: When line_start is high and cur_y equals the target of source n, status bit n (status register at address 0, bit n for source n) is set and is visible from the next cycle. A matching cur_y has no effect while line_start is low.
- R4: A set status bit stays set until it is cleared. Writes to the status address have no effect on it.
- R5: Writing to the clear register at address 1 clears every status bit whose data bit is 1. Data bits that are 0 leave their status bits unchanged. The clear register reads as zero.
- R6: If a status bit is set by a line match and cleared by a write in the same cycle, the bit ends up set.
- R7: The mask register is at address 2, with bit n belonging to source n, and it reads back. irq is high exactly when some status bit and its mask bit are both 1. Status reads the same whatever the mask holds.
- R8: The trigger register is at address 3. It holds the double-buffer load line in bits 12:0 and the single-buffer load line in bits 28:16. db_load and sb_load each pulse high for exactly one cycle, in the cycle after a line_start whose cur_y equals their line.
- R9: When several sources target the same line, that line's start sets all of their status bits together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_y | input | 13 | Current line number from the timing generator |
| line_start | input | 1 | High for the first pixel of each line |
| wr_en | input | 1 | Register write enable |
| addr | input | 3 | Register word address |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data for addr |
| irq | output | 1 | Combined interrupt request, level |
| sb_load | output | 1 | Single-buffered context-load strobe |
| db_load | output | 1 | Double-buffered context-load strobe |

## Verification
The bench points two sources at the same line. A design that compares only the first matching source would leave one of the two status bits clear. It also clears a bit in the same cycle that the bit's line begins. A design that gives the clear priority would lose that event. The bench holds a matching cur_y with line_start low, which catches a design that compares levels instead of waiting for the line strobe. It writes zeros to the clear register and to the status address, which catches logic that disturbs status on a write it should ignore. Finally, it checks the load strobes one cycle after they fire, which catches strobes that linger past a single cycle.

// File: rtl/line_irq_pkg.sv
`timescale 1ns/1ps
package line_irq_pkg;
    localparam int DATA_W     = 32;
    localparam int HI_POS     = 16;
    localparam int LO_POS     = 0;
    localparam int LINE_BASE  = 4;

    localparam logic [2:0] A_STATUS = 3'd0;
    localparam logic [2:0] A_CLEAR  = 3'd1;
    localparam logic [2:0] A_MASK   = 3'd2;
    localparam logic [2:0] A_TRIG   = 3'd3;

    typedef struct packed {
        logic sb;
        logic db;
    } load_t;

    function automatic logic [DATA_W-1:0] place_hi(input logic [15:0] v, input int w);
        logic [DATA_W-1:0] r;
        r = '0;
        for (int b = 0; b < 16; b++)
            if (b < w) r[HI_POS+b] = v[b];
        return r;
    endfunction
endpackage

// File: rtl/lir_regs.sv
`timescale 1ns/1ps
module lir_regs
    import line_irq_pkg::*;
#(
    parameter int N_SRC  = 4,
    parameter int Y_W    = 13,
    parameter int ADDR_W = 3
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [DATA_W-1:0]            wdata,
    output logic [N_SRC-1:0]             mask_q,
    output logic [N_SRC-1:0][Y_W-1:0]    line_q,
    output logic [Y_W-1:0]               sb_line_q,
    output logic [Y_W-1:0]               db_line_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q    <= '0;
            sb_line_q <= '0;
            db_line_q <= '0;
        end else if (wr_en) begin
            if (addr == ADDR_W'(A_MASK))
                mask_q <= wdata[N_SRC-1:0];
            if (addr == ADDR_W'(A_TRIG)) begin
                db_line_q <= wdata[LO_POS +: Y_W];
                sb_line_q <= wdata[HI_POS +: Y_W];
            end
        end
    end

    for (genvar i = 0; i < N_SRC; i++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst)
                line_q[i] <= '0;
            else if (wr_en && addr == ADDR_W'(LINE_BASE + i))
                line_q[i] <= wdata[HI_POS +: Y_W];
        end
    end
endmodule

// File: rtl/lir_match.sv
`timescale 1ns/1ps
module lir_match
    import line_irq_pkg::*;
#(
    parameter int N_SRC = 4,
    parameter int Y_W   = 13
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      line_start,
    input  logic [Y_W-1:0]            cur_y,
    input  logic [N_SRC-1:0][Y_W-1:0] line_q,
    input  logic [Y_W-1:0]            sb_line_q,
    input  logic [Y_W-1:0]            db_line_q,
    output logic [N_SRC-1:0]          hit,
    output load_t                     load_q
);
    for (genvar i = 0; i < N_SRC; i++) begin : g_cmp
        assign hit[i] = line_start && (cur_y == line_q[i]);
    end

    load_t load_d;
    always_comb begin
        load_d.sb = line_start && (cur_y == sb_line_q);
        load_d.db = line_start && (cur_y == db_line_q);
    end

    always_ff @(posedge clk) begin
        if (rst) load_q <= '0;
        else     load_q <= load_d;
    end
endmodule

// File: rtl/lir_status.sv
`timescale 1ns/1ps
module lir_status #(
    parameter int N_SRC = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] hit,
    input  logic             clr_we,
    input  logic [N_SRC-1:0] clr_bits,
    output logic [N_SRC-1:0] status_q
);
    logic [N_SRC-1:0] clr_eff;
    assign clr_eff = clr_we ? clr_bits : '0;

    always_ff @(posedge clk) begin
        if (rst) status_q <= '0;
        else     status_q <= (status_q & ~clr_eff) | hit;
    end
endmodule

// File: rtl/line_irq_unit.sv
`timescale 1ns/1ps
module line_irq_unit
    import line_irq_pkg::*;
#(
    parameter int N_SRC  = 4,
    parameter int Y_W    = 13,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [Y_W-1:0]    cur_y,
    input  logic              line_start,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              irq,
    output logic              sb_load,
    output logic              db_load
);
    logic [N_SRC-1:0]            mask_q;
    logic [N_SRC-1:0][Y_W-1:0]   line_q;
    logic [Y_W-1:0]              sb_line_q;
    logic [Y_W-1:0]              db_line_q;
    logic [N_SRC-1:0]            hit;
    logic [N_SRC-1:0]            status_q;
    load_t                       load_q;

    lir_regs #(.N_SRC(N_SRC), .Y_W(Y_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .mask_q(mask_q), .line_q(line_q), .sb_line_q(sb_line_q), .db_line_q(db_line_q)
    );

    lir_match #(.N_SRC(N_SRC), .Y_W(Y_W)) u_match (
        .clk(clk), .rst(rst), .line_start(line_start), .cur_y(cur_y),
        .line_q(line_q), .sb_line_q(sb_line_q), .db_line_q(db_line_q),
        .hit(hit), .load_q(load_q)
    );

    lir_status #(.N_SRC(N_SRC)) u_status (
        .clk(clk), .rst(rst), .hit(hit),
        .clr_we(wr_en && addr == ADDR_W'(A_CLEAR)),
        .clr_bits(wdata[N_SRC-1:0]), .status_q(status_q)
    );

    assign irq     = |(status_q & mask_q);
    assign sb_load = load_q.sb;
    assign db_load = load_q.db;

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(A_STATUS)) rdata[N_SRC-1:0] = status_q;
        if (addr == ADDR_W'(A_MASK))   rdata[N_SRC-1:0] = mask_q;
        if (addr == ADDR_W'(A_TRIG)) begin
            rdata[LO_POS +: Y_W] = db_line_q;
            rdata[HI_POS +: Y_W] = sb_line_q;
        end
        for (int i = 0; i < N_SRC; i++)
            if (addr == ADDR_W'(LINE_BASE + i))
                rdata = place_hi(16'(line_q[i]), Y_W);
    end
endmodule

// File: rtl/line_irq_unit_chk.sv
`timescale 1ns/1ps
module line_irq_unit_chk
    import line_irq_pkg::*;
#(
    parameter int N_SRC  = 4,
    parameter int Y_W    = 13,
    parameter int ADDR_W = 3
) (
    input logic                      clk,
    input logic                      rst,
    input logic [Y_W-1:0]            cur_y,
    input logic                      line_start,
    input logic                      wr_en,
    input logic [ADDR_W-1:0]         addr,
    input logic [31:0]               wdata,
    input logic                      irq,
    input logic                      sb_load,
    input logic                      db_load,
    input logic [N_SRC-1:0]          status_q,
    input logic [N_SRC-1:0]          mask_q,
    input logic [N_SRC-1:0][Y_W-1:0] line_q
);
    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        // R3 and R6: a line match always leaves the bit set
        assert_status_set_R3: assert property (@(posedge clk) disable iff (rst)
            (line_start && cur_y == line_q[i]) |=> status_q[i]);
        assert_sticky_R4: assert property (@(posedge clk) disable iff (rst)
            (status_q[i] && !(wr_en && addr == ADDR_W'(A_CLEAR) && wdata[i])) |=> status_q[i]);
        assert_clear_R5: assert property (@(posedge clk) disable iff (rst)
            (wr_en && addr == ADDR_W'(A_CLEAR) && wdata[i] && !(line_start && cur_y == line_q[i]))
            |=> !status_q[i]);
    end

    assert_masked_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '0) |-> !irq);
    assert_irq_source_R7: assert property (@(posedge clk) disable iff (rst)
        irq |-> (status_q != '0));
    assert_sb_cause_R8: assert property (@(posedge clk) disable iff (rst)
        sb_load |-> $past(line_start));
    assert_db_cause_R8: assert property (@(posedge clk) disable iff (rst)
        db_load |-> $past(line_start));
endmodule

bind line_irq_unit line_irq_unit_chk #(.N_SRC(N_SRC), .Y_W(Y_W), .ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst(rst), .cur_y(cur_y), .line_start(line_start),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .irq(irq),
    .sb_load(sb_load), .db_load(db_load), .status_q(status_q),
    .mask_q(mask_q), .line_q(line_q)
);

// File: tb/line_irq_unit_test.sv
`timescale 1ns/1ps
module line_irq_unit_test;
    logic        clk = 0;
    logic        rst = 1;
    logic [12:0] cur_y = '0;
    logic        line_start = 0;
    logic        wr_en = 0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, sb_load, db_load;
    int checks = 0;
    int errors = 0;

    line_irq_unit uut (
        .clk(clk), .rst(rst), .cur_y(cur_y), .line_start(line_start),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .irq(irq), .sb_load(sb_load), .db_load(db_load)
    );

    always #10 clk = ~clk;

    // {line 16b, expected status 4b, sb 1b, db 1b}
    localparam logic [21:0] VECS [6] = '{
        {16'd10,  4'b0001, 1'b0, 1'b0},
        {16'd20,  4'b0110, 1'b0, 1'b0},
        {16'd300, 4'b1000, 1'b0, 1'b0},
        {16'd5,   4'b0000, 1'b1, 1'b0},
        {16'd400, 4'b0000, 1'b0, 1'b1},
        {16'd11,  4'b0000, 1'b0, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 0; wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic pulse(input logic [12:0] y);
        @(negedge clk);
        cur_y = y; line_start = 1;
        @(negedge clk);
        line_start = 0;
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        // R1 reset state
        check("R1 irq", {31'd0, irq}, 0);
        check("R1 strobes", {30'd0, sb_load, db_load}, 0);
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), d);
            check("R1 reg zero", d, 0);
        end

        // R2 line register field and readback
        wr(3'd4, 32'hFFFF_FFFF);
        rd(3'd4, d);
        check("R2 field only", d, 32'h1FFF_0000);
        wr(3'd4, 32'd10 << 16);
        wr(3'd5, 32'd20 << 16);
        wr(3'd6, 32'd20 << 16);
        wr(3'd7, 32'd300 << 16);
        rd(3'd7, d);
        check("R2 readback", d, 32'd300 << 16);
        // R8 trigger register: sb=5 at 28:16, db=400 at 12:0
        wr(3'd3, (32'd5 << 16) | 32'd400);
        rd(3'd3, d);
        check("R8 trig readback", d, (32'd5 << 16) | 32'd400);

        // vector walk: R3, R8, R9
        for (int v = 0; v < 6; v++) begin
            wr(3'd1, 32'hF);
            pulse(VECS[v][21:6]);
            check("R8 sb_load", {31'd0, sb_load}, {31'd0, VECS[v][1]});
            check("R8 db_load", {31'd0, db_load}, {31'd0, VECS[v][0]});
            rd(3'd0, d);
            check("R3 R9 status", d, {28'd0, VECS[v][5:2]});
            check("R8 single pulse", {30'd0, sb_load, db_load}, 0);
        end

        // R3 no set without line_start
        wr(3'd1, 32'hF);
        @(negedge clk);
        cur_y = 13'd10;
        repeat (2) @(negedge clk);
        rd(3'd0, d);
        check("R3 no strobe", d, 0);

        // R4 sticky, status address write ignored
        pulse(13'd10);
        repeat (3) @(negedge clk);
        wr(3'd0, 32'h0);
        rd(3'd0, d);
        check("R4 sticky", d, 32'h1);

        // R5 zero write no effect, one clears, reads zero
        wr(3'd1, 32'h0);
        rd(3'd0, d);
        check("R5 zero write", d, 32'h1);
        rd(3'd1, d);
        check("R5 clear reads zero", d, 0);
        wr(3'd1, 32'h1);
        rd(3'd0, d);
        check("R5 cleared", d, 0);

        // R6 set wins over clear
        @(negedge clk);
        cur_y = 13'd10; line_start = 1;
        wr_en = 1; addr = 3'd1; wdata = 32'h1;
        @(negedge clk);
        line_start = 0; wr_en = 0; wdata = '0;
        rd(3'd0, d);
        check("R6 set wins", d, 32'h1);

        // R7 mask behaviour
        check("R7 masked irq low", {31'd0, irq}, 0);
        wr(3'd2, 32'h2);
        rd(3'd2, d);
        check("R7 mask readback", d, 32'h2);
        check("R7 other source masked", {31'd0, irq}, 0);
        wr(3'd2, 32'h1);
        check("R7 irq high", {31'd0, irq}, 1);
        rd(3'd0, d);
        check("R7 status with mask", d, 32'h1);
        wr(3'd1, 32'h1);
        check("R7 irq after clear", {31'd0, irq}, 0);
        wr(3'd2, 32'h0);
        pulse(13'd300);
        rd(3'd0, d);
        check("R7 status mask off", d, 32'h8);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule